// File: doc/BRIEF.md
# Eight-Input Interrupt Controller with Rotating Priority

This controller collects eight level-sensitive interrupt requests for a small CPU and drives one interrupt line. Each request is synchronised and then held in a pending register while it waits for service. A software-written mask filters it, and a priority selector picks one candidate. The interrupt line is raised only when that candidate outranks every routine already running. When the CPU acknowledges, the controller latches an 8-bit vector, clears the pending bit and sets the matching in-service bit.

Software finishes each routine by writing the end-of-interrupt command. That write retires the highest-priority in-service bit, so the input can request again. A configuration bit selects the ordering. Fixed mode ranks input 0 first. Rotating mode moves the input just retired to the bottom of the order, so inputs of equal importance share service fairly.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, vector_o is 0, and the mask, config, pending and in-service registers all read 0, which selects fixed mode.
- R2: A request input is passed through a two-stage synchroniser into the pending register. A level held from one negative edge shows as pending after the third rising edge and not after the second. A level that falls before acknowledge leaves pending three edges later.
- R3: A pending bit is never set for an input that is in service. Pending and in-service never share a bit.
- R4: A pending input whose mask bit is 1 never raises irq_o and is never acknowledged. Its pending bit stays readable.
- R5: In fixed mode, the lowest-numbered unmasked pending input is selected.
- R6: irq_o is high only when the selected candidate ranks above every in-service input. A lower-ranked request waits until the end-of-interrupt write that empties the higher routines.
- R7: ack_i sampled with irq_o high loads vector_o with {base, index} of the selected input, clears its pending bit and sets its in-service bit. ack_i with irq_o low changes nothing.
- R8: A write to address 2 clears only the highest-ranked in-service bit. With nothing in service it has no effect.
- R9: In rotating mode, an end-of-interrupt that retires input k makes k+1 (mod 8) the top rank and k the bottom rank.
- R10: Register map. Address 0 is the mask, read and write, where 1 blocks an input. Address 1 is the config, read and write: bit 0 set means rotating mode, bits 7:3 are the vector base, and bits 2:1 are spare storage. Address 2 reads the pending register and a write to it is the end-of-interrupt command. Address 3 reads the in-service register and ignores writes.
- R11: Fixed mode ignores the stored rotation point, and that point is kept for a later return to rotating mode. End-of-interrupt in fixed mode leaves the rotation point unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 8 | Level-sensitive interrupt requests |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, combinational on addr_i |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_i | input | 1 | Interrupt acknowledge from the CPU |
| vector_o | output | 8 | Vector latched on acknowledge |

## Verification
Some properties are checked on every cycle:
- pending and in-service never overlap;
- irq_o is backed by an unmasked pending bit;
- an acknowledge moves exactly the chosen bit and loads the configured base;
- an idle acknowledge changes nothing;
- an end-of-interrupt removes exactly one in-service bit;
- every priority pick lands on a set bit.

Other behaviour is shown only by the bench's scenarios:
- the synchroniser latency;
- the nesting and ranking decisions;
- the rotation sequence that alternates two held requests;
- the return to fixed order while the rotation point is kept.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_CFG  = 2'd1,
    REG_EOI  = 2'd2,
    REG_ISR  = 2'd3
  } reg_addr_e;

  localparam int unsigned CFG_ROT_BIT = 0;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_prio_pick.sv
// Picks the set bit closest to base_i going upward, wrapping around.
module irq_prio_pick #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     vec_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    logic [IDX_W-1:0] pos;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N-1; k >= 0; k--) begin
      pos = base_i + IDX_W'(k);
      if (vec_i[pos]) begin
        valid_o = 1'b1;
        idx_o   = pos;
      end
    end
  end

  AST_PICK_HITS_SET_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vec_i[idx_o]); // R5
  AST_PICK_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i != '0) |-> valid_o); // R5
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_IRQ       = 8,
  parameter int unsigned BASE_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W  = $clog2(N_IRQ),
  localparam int unsigned DATA_W = N_IRQ,
  localparam int unsigned VEC_W  = BASE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vector_o
);
  logic [N_IRQ-1:0]  req_sync;
  logic [N_IRQ-1:0]  pending_q, isr_q, isr_next, mask_q;
  logic [DATA_W-1:0] cfg_q;
  logic [IDX_W-1:0]  rot_q, base_eff;
  logic              rotate;
  logic [BASE_W-1:0] vec_base;
  logic              cand_valid, isr_valid;
  logic [IDX_W-1:0]  cand_idx, isr_idx, cand_rank, isr_rank;
  logic              ack_take, eoi;

  irq_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_req_i), .q_o(req_sync)
  );

  assign rotate   = cfg_q[CFG_ROT_BIT];
  assign vec_base = cfg_q[DATA_W-1 -: BASE_W];
  assign base_eff = rotate ? rot_q : '0;

  irq_prio_pick #(.N(N_IRQ)) u_pick_cand (
    .clk_i, .rst_ni, .vec_i(pending_q & ~mask_q), .base_i(base_eff),
    .valid_o(cand_valid), .idx_o(cand_idx)
  );

  irq_prio_pick #(.N(N_IRQ)) u_pick_isr (
    .clk_i, .rst_ni, .vec_i(isr_q), .base_i(base_eff),
    .valid_o(isr_valid), .idx_o(isr_idx)
  );

  // Rank distance from the current top slot; smaller ranks higher.
  assign cand_rank = cand_idx - base_eff;
  assign isr_rank  = isr_idx - base_eff;

  assign irq_o    = cand_valid && (!isr_valid || (cand_rank < isr_rank));
  assign ack_take = ack_i && irq_o;
  assign eoi      = wr_en_i && (addr_i == REG_EOI);

  always_comb begin
    isr_next = isr_q;
    if (eoi && isr_valid) isr_next[isr_idx] = 1'b0;
    if (ack_take)         isr_next[cand_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      cfg_q     <= '0;
      rot_q     <= '0;
      vector_o  <= '0;
    end else begin
      pending_q <= req_sync & ~isr_next;
      isr_q     <= isr_next;
      if (ack_take) vector_o <= {vec_base, cand_idx};
      if (eoi && isr_valid && rotate) rot_q <= isr_idx + IDX_W'(1);
      if (wr_en_i && addr_i == REG_MASK) mask_q <= wr_data_i;
      if (wr_en_i && addr_i == REG_CFG)  cfg_q  <= wr_data_i;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_MASK: rd_data_o = mask_q;
      REG_CFG:  rd_data_o = cfg_q;
      REG_EOI:  rd_data_o = pending_q;
      default:  rd_data_o = isr_q;
    endcase
  end

  AST_PEND_ISR_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q & isr_q) == '0); // R3
  AST_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pending_q & ~mask_q) != '0)); // R4
  AST_ACK_MOVES_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (isr_q[$past(cand_idx)] && !pending_q[$past(cand_idx)])); // R7
  AST_ACK_VECTOR_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (vector_o[VEC_W-1 -: BASE_W] == $past(vec_base))); // R7
  AST_ACK_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi) |=> ($stable(isr_q) && $stable(vector_o))); // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack_take && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R8
endmodule

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       ack = 1'b0;
  logic [7:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq),
    .ack_i(ack), .vector_o(vec)
  );

  // {req, mask, expect_irq, expect_idx}; fixed mode
  localparam logic [19:0] TBL [7] = '{
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 1'b1, 3'd7},
    {8'hA4, 8'h00, 1'b1, 3'd2},
    {8'hA4, 8'h04, 1'b1, 3'd5},
    {8'h0F, 8'h0F, 1'b0, 3'd0},
    {8'hFF, 8'h7F, 1'b1, 3'd7},
    {8'h48, 8'h40, 1'b1, 3'd3}
  };
  localparam logic [4:0] BASE = 5'h12;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 vector", vec, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R1 reg", d, 0);
    end

    // R10 register map
    wr(2'd0, 8'h5A); rd(2'd0, d); check("R10 mask rw", d, 8'h5A);
    wr(2'd0, 8'h00);
    wr(2'd1, {BASE, 3'b110}); rd(2'd1, d); check("R10 cfg rw", d, {BASE, 3'b110});
    wr(2'd1, {BASE, 3'b000});
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R10 isr write ignored", d, 0);

    // R2 latency and level drop
    req = 8'h10;
    cyc(2); rd(2'd2, d); check("R2 not yet pending", d, 0);
    cyc(1); rd(2'd2, d); check("R2 pending after 3 edges", d, 8'h10);
    check("R2 irq", irq, 1);
    req = 8'h00;
    cyc(3); rd(2'd2, d); check("R2 drop clears pending", d, 0);
    check("R2 irq drop", irq, 0);

    // R7 idle acknowledge ignored
    do_ack();
    check("R7 idle ack vector", vec, 0);
    rd(2'd3, d); check("R7 idle ack isr", d, 0);

    // R4 R5 table walk
    for (int i = 0; i < 7; i++) begin
      logic [19:0] e;
      e = TBL[i];
      wr(2'd0, e[11:4]);
      req = e[19:12];
      cyc(3);
      check("R5 R4 irq", irq, e[3]);
      if (e[3]) begin
        do_ack();
        check("R5 R7 vector", vec, {BASE, e[2:0]});
        rd(2'd3, d); check("R7 isr set", d, 8'h01 << e[2:0]);
        req = 8'h00; cyc(3);
        wr(2'd2, 8'h00);
        rd(2'd3, d); check("R8 isr cleared", d, 0);
      end else begin
        rd(2'd2, d); check("R4 masked still pending", d, e[19:12]);
        req = 8'h00; cyc(3);
      end
    end
    wr(2'd0, 8'h00);

    // R6 nesting, R3, R8
    req = 8'h20; cyc(3);
    do_ack(); check("R6 vec5", vec, {BASE, 3'd5});
    req = 8'h60; cyc(3);
    check("R6 lower waits", irq, 0);
    rd(2'd2, d); check("R3 in-service not pending", d, 8'h40);
    req = 8'h64; cyc(3);
    check("R6 higher preempts", irq, 1);
    do_ack(); check("R6 vec2", vec, {BASE, 3'd2});
    rd(2'd3, d); check("R6 nested isr", d, 8'h24);
    req = 8'h60; cyc(3);
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R8 clears highest only", d, 8'h20);
    check("R6 still blocked", irq, 0);
    wr(2'd2, 8'h00);
    check("R6 released", irq, 1);
    do_ack(); check("R6 vec5 again", vec, {BASE, 3'd5});
    req = 8'h00; cyc(3);
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R8 isr empty", d, 0);
    wr(2'd2, 8'h00);
    rd(2'd3, d); check("R8 empty eoi isr", d, 0);
    rd(2'd2, d); check("R8 empty eoi pending", d, 0);
    check("R8 empty eoi irq", irq, 0);

    // R9 R11 rotation
    wr(2'd1, {BASE, 3'b001});
    req = 8'h0A; cyc(3);
    do_ack(); check("R9 first pick 1", vec, {BASE, 3'd1});
    check("R9 3 waits", irq, 0);
    wr(2'd2, 8'h00);
    check("R9 irq after eoi", irq, 1);
    do_ack(); check("R9 rotated pick 3", vec, {BASE, 3'd3});
    wr(2'd2, 8'h00);
    do_ack(); check("R9 rotated pick 1", vec, {BASE, 3'd1});
    check("R9 3 now lower", irq, 0);
    wr(2'd2, 8'h00);
    wr(2'd1, {BASE, 3'b000});
    do_ack(); check("R11 fixed ignores rotation", vec, {BASE, 3'd1});
    wr(2'd2, 8'h00);
    wr(2'd1, {BASE, 3'b001});
    do_ack(); check("R11 rotation point kept", vec, {BASE, 3'd3});
    wr(2'd2, 8'h00);
    req = 8'h00; cyc(3);
    check("R9 idle end", irq, 0);

    finish_run();
  end
endmodule